// File: doc/BRIEF.md
# DRAM Mode Register and Burst Column Sequencer

This block sits on the memory side of a four-bank double-data-rate DRAM command bus. It samples the active-low chip-select, row-strobe, column-strobe and write-enable inputs, together with the bank and address inputs, on each rising clock edge. When the command is a register write, it programs one of two configuration registers. The normal register holds the burst length, the burst ordering and the read latency. The extended register holds the delay-locked-loop enable and the output drive strength. Bank bit 0 picks which of the two registers is written.

Each read or write command then starts a burst. During the burst the block gives out one column address per beat. The order follows the programmed burst length and ordering: sequential wrap or interleave.

A programming attempt is refused if any bank is open, if it arrives inside the settling window after an accepted write, or if it carries a reserved code. A refused attempt raises a one-cycle error and leaves the stored value untouched. A column command is also refused in three cases: when the normal register has never been programmed, when it arrives inside the settling window, and when it is a read issued on the edge right after a write.

The beat outputs form a valid-only stream. There is no ready input, because the DRAM command bus cannot be stalled. A consumer must accept a beat in every cycle that `beat_valid` is high.

Top module: `dram_modereg_seq`

## Requirements
- R1: While and after reset, and until the first accepted write of each register, `mode_valid`, `ext_valid`, `cfg_err` and `beat_valid` are all 0.
- R2: A register write is a sampled command with cs_n, ras_n, cas_n and we_n all low. With ba[0]=0 and legal fields, the normal register is loaded in the cycle after the edge. The fields are:
  - burst length from addr[2:0]: 001→2, 010→4, 011→8, shown on `burst_len`;
  - `burst_ilv` = addr[3], where 1 means interleave;
  - `rd_latency` from addr[6:4]: 010→2, 011→3.
  
  `mode_valid` goes to 1 and stays 1.
- R3: With ba[0]=1, the extended register is loaded. `dll_on` = NOT addr[0]. `drive_sel` = {addr[6], addr[1]}, where 00 is full, 01 is weak and 11 is matched. `ext_valid` goes to 1.
- R4: A reserved code raises `cfg_err` in the next cycle and changes no stored field.
  - In the normal register, these codes are reserved: a burst code outside 001..011, a latency code other than 010/011, and any 1 in addr[11:7] or ba[1].
  - In the extended register, these codes are reserved: {addr[6], addr[1]} = 10, and any 1 in addr[5:2], addr[11:7] or ba[1].
- R5: Bank state is tracked from the command inputs.
  - Activate (ras_n=0, cas_n=1, we_n=1) opens bank `ba`.
  - Precharge (ras_n=0, cas_n=1, we_n=0) closes bank `ba`. It closes every bank when addr[10]=1.
  - A register write while any bank is open is refused with `cfg_err` and stores nothing.
- R6: If a register write is accepted at edge k, any non-NOP command sampled at edge k+1 is ignored and raises `cfg_err`. Commands at edge k+2 are accepted normally.
- R7: With `mode_valid`=1, a read (ras_n=1, cas_n=0, we_n=1) or a write (we_n=0) starts a burst. `beat_valid` is high for exactly `burst_len` cycles, starting in the cycle after the command edge. `beat_last` marks the final beat. `beat_write` and `beat_bank` reflect the command.
- R8: In sequential order, the low log2(length) bits of the start column count up by one per beat and wrap inside the burst. The upper bits stay fixed.
- R9: In interleave order, beat i carries the start column's low log2(length) bits XORed with i. The upper bits stay fixed.
- R10: A column command while `mode_valid`=0 raises `cfg_err` and produces no beat.
- R11: A read sampled on the edge directly after an accepted write is refused with `cfg_err`, and the write burst continues. A read two edges after the write is accepted.
- R12: An accepted column command during a running burst ends that burst. From the next cycle the new burst starts at its own beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address; bit 0 picks the register for a register write |
| addr | input | ADDR_W | Row/column address and register field value |
| mode_valid | output | 1 | Normal register has been legally written |
| burst_len | output | 4 | Beats per burst (2, 4 or 8) |
| burst_ilv | output | 1 | 1 = interleave order, 0 = sequential |
| rd_latency | output | 3 | Read latency in clocks (2 or 3) |
| ext_valid | output | 1 | Extended register has been legally written |
| dll_on | output | 1 | Delay-locked loop enabled |
| drive_sel | output | 2 | Drive strength: 00 full, 01 weak, 11 matched |
| cfg_err | output | 1 | One-cycle pulse for a refused command |
| beat_valid | output | 1 | A burst beat is present this cycle |
| beat_write | output | 1 | Current burst came from a write |
| beat_bank | output | BA_W | Bank of the current burst |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the last of its burst |

## Verification
The bench targets the settling window at exactly one edge. It sends a second register write and an activate there, then proves the activate had no effect by programming successfully on the next edge. A design with an off-by-one window would either accept too early or lock out the legal edge.

Each reserved field is sent one at a time against a known stored value. The bench also checks refusal with a bank left open after a partial precharge and after a full precharge. A design that ignored one field, or that updated the register before validating it, would show a changed setting.

Burst order is checked with start columns whose low bits are non-zero at every length, in both orders. This catches wrap carried into upper bits, or interleave applied as addition. The read-right-after-write and mid-burst restart cases expose designs that let the refused read cut the write short, or that keep counting the old burst.

// File: rtl/mr_seq_pkg.sv
package mr_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4,
    CMD_MRS = 3'd5,
    CMD_REF = 3'd6,
    CMD_OTH = 3'd7
  } cmd_e;

  // Strobe pattern {ras_n, cas_n, we_n} to command kind
  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) begin
      c = CMD_NOP;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_NOP;
        3'b011:  c = CMD_ACT;
        3'b010:  c = CMD_PRE;
        3'b101:  c = CMD_RD;
        3'b100:  c = CMD_WR;
        3'b000:  c = CMD_MRS;
        3'b001:  c = CMD_REF;
        default: c = CMD_OTH;
      endcase
    end
    return c;
  endfunction

  // Burst-length code to beat count; 0 marks a reserved code
  function automatic logic [3:0] len_of_code(input logic [2:0] code);
    logic [3:0] n;
    case (code)
      3'b001:  n = 4'd2;
      3'b010:  n = 4'd4;
      3'b011:  n = 4'd8;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

  function automatic logic lat_code_ok(input logic [2:0] code);
    return (code == 3'b010) || (code == 3'b011);
  endfunction

endpackage

// File: rtl/mr_cmd_decode.sv
module mr_cmd_decode
  import mr_seq_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);
  end

endmodule

// File: rtl/mr_bank_track.sv
module mr_bank_track
  import mr_seq_pkg::*;
#(
  parameter int BA_W = 2,
  localparam int BANKS = 1 << BA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic             gate,
  input  logic [BA_W-1:0]  ba,
  input  logic             all_sel,
  output logic [BANKS-1:0] open_mask,
  output logic             all_idle
);

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_mask[g] <= 1'b0;
      end else if (gate) begin
        if (cmd == CMD_ACT && ba == BA_W'(g)) begin
          open_mask[g] <= 1'b1;
        end else if (cmd == CMD_PRE && (all_sel || ba == BA_W'(g))) begin
          open_mask[g] <= 1'b0;
        end
      end
    end
  end

  assign all_idle = (open_mask == '0);

endmodule

// File: rtl/mr_regfile.sv
module mr_regfile
  import mr_seq_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int BA_W    = 2,
  parameter int MRD_CYC = 2,
  localparam int CNT_W  = $clog2(MRD_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              all_idle,
  output logic              mode_valid,
  output logic [3:0]        burst_len,
  output logic              burst_ilv,
  output logic [2:0]        rd_latency,
  output logic              ext_valid,
  output logic              dll_on,
  output logic [1:0]        drive_sel,
  output logic              win_busy,
  output logic              err_reg
);

  // Extended-register bits that carry meaning: 0, 1 and 6
  localparam logic [ADDR_W-1:0] EXT_USED = ADDR_W'(7'b100_0011);

  logic [CNT_W-1:0] busy_cnt;
  logic             hi_ba_set;
  logic             nrm_legal;
  logic             ext_legal;
  logic             attempt;
  logic             accept;
  logic [3:0]       new_len;

  assign win_busy  = (busy_cnt != '0);
  assign hi_ba_set = |ba[BA_W-1:1];
  assign new_len   = len_of_code(addr[2:0]);

  assign nrm_legal = (new_len != 4'd0) && lat_code_ok(addr[6:4]) &&
                     !(|addr[ADDR_W-1:7]) && !hi_ba_set;
  assign ext_legal = !(|(addr & ~EXT_USED)) && !hi_ba_set &&
                     ({addr[6], addr[1]} != 2'b10);

  assign attempt = (cmd == CMD_MRS) && !win_busy;
  assign accept  = attempt && all_idle && (ba[0] ? ext_legal : nrm_legal);
  assign err_reg = (attempt && !accept) || (win_busy && cmd != CMD_NOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (accept) begin
      busy_cnt <= CNT_W'(MRD_CYC - 1);
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_valid <= 1'b0;
      burst_len  <= '0;
      burst_ilv  <= 1'b0;
      rd_latency <= '0;
    end else if (accept && !ba[0]) begin
      mode_valid <= 1'b1;
      burst_len  <= new_len;
      burst_ilv  <= addr[3];
      rd_latency <= addr[6:4];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_valid <= 1'b0;
      dll_on    <= 1'b0;
      drive_sel <= '0;
    end else if (accept && ba[0]) begin
      ext_valid <= 1'b1;
      dll_on    <= !addr[0];
      drive_sel <= {addr[6], addr[1]};
    end
  end

endmodule

// File: rtl/mr_burst_gen.sv
module mr_burst_gen
  import mr_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int BA_W   = 2,
  parameter int MAX_BL = 8,
  localparam int IDX_W = $clog2(MAX_BL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic             gate,
  input  logic             mode_valid,
  input  logic [3:0]       burst_len,
  input  logic             burst_ilv,
  input  logic [BA_W-1:0]  ba,
  input  logic [COL_W-1:0] col,
  output logic             beat_valid,
  output logic             beat_write,
  output logic [BA_W-1:0]  beat_bank,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             err_col
);

  logic             run;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] len_m1;
  logic             ilv_q;
  logic [COL_W-1:0] base;
  logic             prev_wr;
  logic             is_col;
  logic             start;
  logic [IDX_W-1:0] lo;
  logic [IDX_W-1:0] new_lo;

  assign is_col  = gate && (cmd == CMD_RD || cmd == CMD_WR);
  assign start   = is_col && mode_valid && !(cmd == CMD_RD && prev_wr);
  assign err_col = is_col && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= 1'b0;
      idx        <= '0;
      len_m1     <= '0;
      ilv_q      <= 1'b0;
      base       <= '0;
      beat_bank  <= '0;
      beat_write <= 1'b0;
      prev_wr    <= 1'b0;
    end else begin
      prev_wr <= start && (cmd == CMD_WR);
      if (start) begin
        run        <= 1'b1;
        idx        <= '0;
        len_m1     <= IDX_W'(burst_len - 4'd1);
        ilv_q      <= burst_ilv;
        base       <= col;
        beat_bank  <= ba;
        beat_write <= (cmd == CMD_WR);
      end else if (run) begin
        if (idx == len_m1) begin
          run <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // Low bits wrap inside the burst; len_m1 doubles as the wrap mask
  always_comb begin
    lo = base[IDX_W-1:0];
    if (ilv_q) begin
      new_lo = lo ^ idx;
    end else begin
      new_lo = (lo & ~len_m1) | ((lo + idx) & len_m1);
    end
  end

  assign beat_valid = run;
  assign beat_col   = {base[COL_W-1:IDX_W], new_lo};
  assign beat_last  = run && (idx == len_m1);

endmodule

// File: rtl/dram_modereg_seq.sv
module dram_modereg_seq
  import mr_seq_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int COL_W   = 9,
  parameter int BA_W    = 2,
  parameter int MRD_CYC = 2,
  parameter int MAX_BL  = 8,
  parameter int AP_BIT  = 10,
  localparam int BANKS  = 1 << BA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              mode_valid,
  output logic [3:0]        burst_len,
  output logic              burst_ilv,
  output logic [2:0]        rd_latency,
  output logic              ext_valid,
  output logic              dll_on,
  output logic [1:0]        drive_sel,
  output logic              cfg_err,
  output logic              beat_valid,
  output logic              beat_write,
  output logic [BA_W-1:0]   beat_bank,
  output logic [COL_W-1:0]  beat_col,
  output logic              beat_last
);

  cmd_e             cmd;
  logic             win_busy;
  logic [BANKS-1:0] open_mask;
  logic             all_idle;
  logic             err_reg;
  logic             err_col;

  mr_cmd_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd)
  );

  mr_bank_track #(.BA_W(BA_W)) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .gate     (!win_busy),
    .ba       (ba),
    .all_sel  (addr[AP_BIT]),
    .open_mask(open_mask),
    .all_idle (all_idle)
  );

  mr_regfile #(.ADDR_W(ADDR_W), .BA_W(BA_W), .MRD_CYC(MRD_CYC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .ba        (ba),
    .addr      (addr),
    .all_idle  (all_idle),
    .mode_valid(mode_valid),
    .burst_len (burst_len),
    .burst_ilv (burst_ilv),
    .rd_latency(rd_latency),
    .ext_valid (ext_valid),
    .dll_on    (dll_on),
    .drive_sel (drive_sel),
    .win_busy  (win_busy),
    .err_reg   (err_reg)
  );

  mr_burst_gen #(.COL_W(COL_W), .BA_W(BA_W), .MAX_BL(MAX_BL)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .gate      (!win_busy),
    .mode_valid(mode_valid),
    .burst_len (burst_len),
    .burst_ilv (burst_ilv),
    .ba        (ba),
    .col       (addr[COL_W-1:0]),
    .beat_valid(beat_valid),
    .beat_write(beat_write),
    .beat_bank (beat_bank),
    .beat_col  (beat_col),
    .beat_last (beat_last),
    .err_col   (err_col)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_err <= 1'b0;
    end else begin
      cfg_err <= err_reg | err_col;
    end
  end

endmodule

// File: rtl/mr_seq_checker.sv
module mr_seq_checker #(
  parameter int BA_W = 2,
  localparam int BANKS = 1 << BA_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             mode_valid,
  input logic [3:0]       burst_len,
  input logic [2:0]       rd_latency,
  input logic             cfg_err,
  input logic             beat_valid,
  input logic             beat_last,
  input logic             win_busy,
  input logic [BANKS-1:0] open_mask
);

  logic reg_wr;
  logic any_cmd;
  assign reg_wr  = !cs_n && !ras_n && !cas_n && !we_n;
  assign any_cmd = !cs_n && !(ras_n && cas_n && we_n);

  p_valid_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |=> mode_valid);

  p_fields_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> ((rd_latency == 3'd2 || rd_latency == 3'd3) &&
                    (burst_len == 4'd2 || burst_len == 4'd4 || burst_len == 4'd8)));

  p_open_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !win_busy && (open_mask != '0)) |=>
      (cfg_err && $stable(burst_len) && $stable(rd_latency)));

  p_window_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_busy && any_cmd) |=> cfg_err);

  p_burst_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> beat_valid);

  p_no_beat_unset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> mode_valid);

endmodule

bind dram_modereg_seq mr_seq_checker #(.BA_W(BA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .mode_valid(mode_valid),
  .burst_len (burst_len),
  .rd_latency(rd_latency),
  .cfg_err   (cfg_err),
  .beat_valid(beat_valid),
  .beat_last (beat_last),
  .win_busy  (win_busy),
  .open_mask (open_mask)
);

// File: tb/dram_modereg_seq_test.sv
module dram_modereg_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic        mode_valid, burst_ilv, ext_valid, dll_on, cfg_err;
  logic [3:0]  burst_len;
  logic [2:0]  rd_latency;
  logic [1:0]  drive_sel;
  logic        beat_valid, beat_write, beat_last;
  logic [1:0]  beat_bank;
  logic [8:0]  beat_col;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dram_modereg_seq uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .mode_valid(mode_valid),
    .burst_len(burst_len), .burst_ilv(burst_ilv), .rd_latency(rd_latency),
    .ext_valid(ext_valid), .dll_on(dll_on), .drive_sel(drive_sel),
    .cfg_err(cfg_err), .beat_valid(beat_valid), .beat_write(beat_write),
    .beat_bank(beat_bank), .beat_col(beat_col), .beat_last(beat_last)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive one command at a falling edge, let one rising edge sample it,
  // return at the next falling edge with NOP on the bus.
  task automatic issue(input logic [3:0] pat, input logic [1:0] b, input logic [11:0] a);
    {cs_n, ras_n, cas_n, we_n} = pat;
    ba = b;
    addr = a;
    @(posedge clk);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  localparam logic [3:0] P_MRS = 4'b0000;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;

  function automatic int exp_col(input int base, input int i, input int len, input bit ilv);
    int lo = base % len;
    int hi = base - lo;
    return ilv ? hi + (lo ^ i) : hi + ((lo + i) % len);
  endfunction

  task automatic set_mode(input logic [11:0] a);
    issue(P_MRS, 2'b00, a);
    chk("R2 program accepted", cfg_err, 0);
    idle(1);
  endtask

  // Beat 0 is on the outputs already; walk the rest and the drop after it
  task automatic walk_beats(input string tag, input int base, input int len, input bit ilv,
                            input bit wr, input logic [1:0] b);
    for (int i = 0; i < len; i++) begin
      if (i > 0) idle(1);
      chk({tag, " valid"}, beat_valid, 1);
      chk({tag, " col"}, beat_col, exp_col(base, i, len, ilv));
      chk({tag, " last"}, beat_last, (i == len - 1));
      chk({tag, " write"}, beat_write, wr);
      chk({tag, " bank"}, beat_bank, b);
    end
    idle(1);
    chk({tag, " end"}, beat_valid, 0);
  endtask

  task automatic t_reset;
    chk("R1 mode_valid", mode_valid, 0);
    chk("R1 ext_valid", ext_valid, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 beat_valid", beat_valid, 0);
  endtask

  task automatic t_unprogrammed;
    issue(P_RD, 2'd0, 12'h005);
    chk("R10 error", cfg_err, 1);
    chk("R10 no beat", beat_valid, 0);
    idle(1);
    chk("R10 still no beat", beat_valid, 0);
    chk("R10 pulse ends", cfg_err, 0);
  endtask

  task automatic t_normal_and_window;
    issue(P_MRS, 2'd0, 12'h032);
    chk("R2 valid", mode_valid, 1);
    chk("R2 len", burst_len, 4);
    chk("R2 ilv", burst_ilv, 0);
    chk("R2 lat", rd_latency, 3);
    chk("R2 no err", cfg_err, 0);
    issue(P_MRS, 2'd0, 12'h02B);
    chk("R6 busy err", cfg_err, 1);
    chk("R6 busy len kept", burst_len, 4);
    issue(P_MRS, 2'd0, 12'h02B);
    chk("R6 k+2 accepted", cfg_err, 0);
    chk("R6 len", burst_len, 8);
    chk("R2 ilv set", burst_ilv, 1);
    chk("R2 lat 2", rd_latency, 2);
    issue(P_ACT, 2'd1, 12'h000);
    chk("R6 act in window err", cfg_err, 1);
    issue(P_MRS, 2'd0, 12'h032);
    chk("R6 act was ignored", cfg_err, 0);
    chk("R6 len back to 4", burst_len, 4);
    idle(1);
  endtask

  task automatic t_reserved;
    logic [11:0] bad_nrm [5] = '{12'h034, 12'h042, 12'h132, 12'h0B2, 12'h232};
    foreach (bad_nrm[k]) begin
      issue(P_MRS, 2'd0, bad_nrm[k]);
      chk("R4 normal reserved err", cfg_err, 1);
      chk("R4 len kept", burst_len, 4);
      chk("R4 lat kept", rd_latency, 3);
    end
    issue(P_MRS, 2'd2, 12'h032);
    chk("R4 high bank bit err", cfg_err, 1);
    chk("R4 ilv kept", burst_ilv, 0);
    issue(P_MRS, 2'd1, 12'h040);
    chk("R4 drive 10 err", cfg_err, 1);
    chk("R4 ext still unset", ext_valid, 0);
    issue(P_MRS, 2'd1, 12'h004);
    chk("R4 ext rfu err", cfg_err, 1);
    chk("R4 ext still unset 2", ext_valid, 0);
  endtask

  task automatic t_extended;
    issue(P_MRS, 2'd1, 12'h042);
    chk("R3 no err", cfg_err, 0);
    chk("R3 valid", ext_valid, 1);
    chk("R3 dll on", dll_on, 1);
    chk("R3 matched", drive_sel, 2'b11);
    chk("R3 normal untouched", burst_len, 4);
    idle(1);
    issue(P_MRS, 2'd1, 12'h003);
    chk("R3 dll off", dll_on, 0);
    chk("R3 weak", drive_sel, 2'b01);
    idle(1);
    issue(P_MRS, 2'd1, 12'h000);
    chk("R3 full", drive_sel, 2'b00);
    chk("R3 dll on again", dll_on, 1);
    idle(1);
  endtask

  task automatic t_banks;
    issue(P_ACT, 2'd2, 12'h000);
    chk("R5 act ok", cfg_err, 0);
    issue(P_MRS, 2'd0, 12'h02B);
    chk("R5 open refuse", cfg_err, 1);
    chk("R5 len kept", burst_len, 4);
    issue(P_PRE, 2'd2, 12'h000);
    issue(P_MRS, 2'd0, 12'h02B);
    chk("R5 closed accept", cfg_err, 0);
    chk("R5 len 8", burst_len, 8);
    idle(1);
    issue(P_ACT, 2'd0, 12'h000);
    issue(P_ACT, 2'd3, 12'h000);
    issue(P_PRE, 2'd0, 12'h000);
    issue(P_MRS, 2'd0, 12'h032);
    chk("R5 bank3 open refuse", cfg_err, 1);
    chk("R5 len still 8", burst_len, 8);
    issue(P_PRE, 2'd1, 12'h400);
    issue(P_MRS, 2'd0, 12'h032);
    chk("R5 all closed accept", cfg_err, 0);
    chk("R5 len 4", burst_len, 4);
    idle(1);
  endtask

  task automatic t_sequential;
    set_mode(12'h033);
    issue(P_RD, 2'd1, 12'h0D5);
    walk_beats("R7 R8 seq8", 'h0D5, 8, 0, 0, 2'd1);
    set_mode(12'h031);
    issue(P_WR, 2'd2, 12'h003);
    walk_beats("R7 R8 seq2", 'h003, 2, 0, 1, 2'd2);
  endtask

  task automatic t_interleave;
    set_mode(12'h03A);
    issue(P_RD, 2'd3, 12'h1A6);
    walk_beats("R9 ilv4", 'h1A6, 4, 1, 0, 2'd3);
    set_mode(12'h03B);
    issue(P_RD, 2'd0, 12'h0F3);
    walk_beats("R9 ilv8", 'h0F3, 8, 1, 0, 2'd0);
  endtask

  task automatic t_read_after_write;
    set_mode(12'h032);
    issue(P_WR, 2'd0, 12'h010);
    chk("R11 wr beat0", beat_col, 'h010);
    issue(P_RD, 2'd0, 12'h100);
    chk("R11 early read err", cfg_err, 1);
    chk("R11 write continues", beat_col, 'h011);
    chk("R11 still write", beat_write, 1);
    idle(2);
    chk("R11 write last", beat_last, 1);
    idle(1);
    chk("R11 write done", beat_valid, 0);
    issue(P_WR, 2'd0, 12'h020);
    idle(1);
    chk("R11 wr beat1", beat_col, 'h021);
    issue(P_RD, 2'd1, 12'h104);
    chk("R11 late read ok", cfg_err, 0);
    chk("R12 read takes over", beat_col, 'h104);
    chk("R12 read kind", beat_write, 0);
    idle(4);
    chk("R12 read done", beat_valid, 0);
  endtask

  task automatic t_interrupt;
    set_mode(12'h033);
    issue(P_RD, 2'd2, 12'h020);
    idle(1);
    chk("R12 old beat1", beat_col, 'h021);
    issue(P_RD, 2'd2, 12'h047);
    walk_beats("R12 restart", 'h047, 8, 0, 0, 2'd2);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_unprogrammed();
    t_normal_and_window();
    t_reserved();
    t_extended();
    t_banks();
    t_sequential();
    t_interleave();
    t_read_after_write();
    t_interrupt();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule